// File: doc/BRIEF.md
# Shifter Operand Generator with Carry-Out

This block is the combinational operand stage in front of a 32-bit data-processing ALU. It builds the ALU's second operand and the shifter carry-out from one of three sources. The first source is a short immediate rotated right by an even amount. The second is a register value shifted by a 5-bit amount held in the instruction. The third is a register value shifted by the low byte of a second register.

The instruction decoder supplies the source select, the shift kind, the amount fields and the current carry flag. The register file supplies the operand register and the low byte of the amount register, and also says whether either read was the program counter. The ALU takes `operand` directly and uses `carry_out` as the shifter carry for logical operations. Reading registers, the ALU itself and writing back the flags are left to the neighbouring blocks.

Top module: `opnd_shift_unit`

## Requirements
- R1: With `src_sel` = 0, `operand` is `imm_val` zero-extended and rotated right by 2 × `rot_fld`. `carry_out` is `operand[31]` when `rot_fld` is non-zero and `carry_in` when it is zero, in which case the value passes through unrotated.
- R2: `src_sel` selects the source: 0 is the rotated immediate, 1 is a register shifted by `sh_imm`, and 2 or 3 (bit 1 set) is a register shifted by `amt_lo`. When every input is zero, `operand` and `carry_out` are zero.
- R3: `sh_kind` encodes 0 = logical left, 1 = logical right, 2 = arithmetic right, 3 = rotate right. A logical left by an immediate of 0 passes the value and `carry_in` through unchanged.
- R4: With an immediate amount, a logical-right or arithmetic-right shift by 0 acts as a shift by 32.
- R5: With an immediate amount, a rotate-right by 0 is a one-bit rotate through the carry: `operand` = {`carry_in`, value[31:1]} and `carry_out` = value[0].
- R6: With a register amount, logical shifts by 32 give 0, with carry value[0] for left and value[31] for right. Logical shifts by more than 32 give 0 with carry 0.
- R7: With a register amount, arithmetic right shifts by 32 or more fill every bit with value[31], and `carry_out` is value[31].
- R8: A register amount whose low byte is 0 leaves both the value and `carry_in` unchanged, whatever the shift kind.
- R9: A register-amount rotate by a non-zero amount uses the amount modulo 32. A non-zero multiple of 32 returns the value unchanged, with `carry_out` = value[31].
- R10: In register-amount mode only, a program-counter read adds 4 to the shifted value (`reg_is_pc`) and to the amount (`amt_is_pc`). In the other modes these flags have no effect.
- R11: For any shift by an amount between 1 and 31, `carry_out` is the last bit shifted out of the value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_sel | input | 2 | Operand source: 0 immediate rotate, 1 immediate amount, 2/3 register amount |
| imm_val | input | 8 | Immediate value for source 0 |
| rot_fld | input | 4 | Rotate field, rotate = 2 × field |
| reg_val | input | 32 | Register value to shift |
| reg_is_pc | input | 1 | `reg_val` was read from the program counter |
| sh_kind | input | 2 | Shift kind: 0 LSL, 1 LSR, 2 ASR, 3 ROR |
| sh_imm | input | 5 | Immediate shift amount |
| amt_lo | input | 8 | Low byte of the amount register |
| amt_is_pc | input | 1 | Amount register was the program counter |
| carry_in | input | 1 | Current carry flag |
| operand | output | 32 | Shifted or rotated operand |
| carry_out | output | 1 | Shifter carry-out |

## Verification
Both outputs are purely combinational, so each result is due within the same cycle its inputs are applied, with no register in the path. The driver applies a stimulus just after a rising edge and pushes the expected pair into a queue. The monitor pops that pair at the next falling edge, half a period later, when the inputs have long settled. Expected values come from a model that shifts one bit per step and uses the full amount byte without clamping. This checks the saturation rules against plain bit-by-bit arithmetic.

// File: rtl/opsh_pkg.sv
package opsh_pkg;
  typedef enum logic [1:0] {
    SH_LSL = 2'd0,
    SH_LSR = 2'd1,
    SH_ASR = 2'd2,
    SH_ROR = 2'd3
  } sh_kind_e;

  localparam logic [1:0] SRC_IMM_ROT = 2'd0;
  localparam logic [1:0] SRC_IMM_AMT = 2'd1;
endpackage

// File: rtl/osg_imm_rot.sv
module osg_imm_rot #(
  parameter int W     = 32,
  parameter int IMM_W = 8,
  parameter int ROT_W = 4,
  localparam int RA_W = ROT_W + 1
) (
  input  logic [IMM_W-1:0] imm,
  input  logic [ROT_W-1:0] rot,
  input  logic             cin,
  output logic [W-1:0]     dout,
  output logic             cout
);
  function automatic logic [W-1:0] f_ror(logic [W-1:0] v, logic [RA_W-1:0] n);
    logic [2*W-1:0] w;
    w = {v, v} >> n;
    return w[W-1:0];
  endfunction

  logic [RA_W-1:0] rot_amt;
  assign rot_amt = {rot, 1'b0};
  assign dout    = f_ror({{(W-IMM_W){1'b0}}, imm}, rot_amt);
  assign cout    = (rot == '0) ? cin : dout[W-1];

  always_comb begin
    if (rot == '0)
      p_rot0_pass_r1: assert (dout[IMM_W-1:0] == imm && cout == cin);
  end
endmodule

// File: rtl/osg_amount_norm.sv
module osg_amount_norm
  import opsh_pkg::*;
#(
  parameter int W     = 32,
  parameter int AMT_W = 8,
  localparam int SW   = $clog2(W),
  localparam int AW   = SW + 1
) (
  input  logic             reg_mode,
  input  sh_kind_e         kind,
  input  logic [SW-1:0]    imm_amt,
  input  logic [AMT_W-1:0] reg_amt,
  output logic [AW-1:0]    amt,
  output logic             rrx
);
  always_comb begin
    amt = '0;
    rrx = 1'b0;
    if (!reg_mode) begin
      unique case (kind)
        SH_LSL:         amt = AW'(imm_amt);
        SH_LSR, SH_ASR: amt = (imm_amt == '0) ? AW'(W) : AW'(imm_amt);
        default: begin
          if (imm_amt == '0) rrx = 1'b1;
          else               amt = AW'(imm_amt);
        end
      endcase
    end else begin
      unique case (kind)
        SH_LSL, SH_LSR: amt = (reg_amt > AMT_W'(W))  ? AW'(W + 1) : AW'(reg_amt);
        SH_ASR:         amt = (reg_amt >= AMT_W'(W)) ? AW'(W)     : AW'(reg_amt);
        default: begin
          if (reg_amt != '0)
            amt = (reg_amt[SW-1:0] == '0) ? AW'(W) : AW'(reg_amt[SW-1:0]);
        end
      endcase
    end
  end

  always_comb begin
    p_amt_bound_r6: assert (amt <= AW'(W + 1));
    if (reg_mode && kind == SH_ASR)
      p_asr_cap_r7: assert (amt <= AW'(W));
    if (rrx)
      p_rrx_no_amt_r5: assert (amt == '0 && !reg_mode);
  end
endmodule

// File: rtl/osg_shift_core.sv
module osg_shift_core
  import opsh_pkg::*;
#(
  parameter int W  = 32,
  localparam int AW = $clog2(W) + 1
) (
  input  sh_kind_e      kind,
  input  logic [AW-1:0] amt,
  input  logic          rrx,
  input  logic [W-1:0]  din,
  input  logic          cin,
  output logic [W-1:0]  dout,
  output logic          cout
);
  // each returns {carry, data}
  function automatic logic [W:0] f_lsl(logic [W-1:0] v, logic [AW-1:0] n);
    logic [2*W-1:0] w;
    w = {{W{1'b0}}, v} << n;
    return w[W:0];
  endfunction

  function automatic logic [W:0] f_lsr(logic [W-1:0] v, logic [AW-1:0] n);
    logic [2*W-1:0] w;
    w = {v, {W{1'b0}}} >> n;
    return {w[W-1], w[2*W-1:W]};
  endfunction

  function automatic logic [W:0] f_asr(logic [W-1:0] v, logic [AW-1:0] n);
    logic signed [2*W-1:0] w;
    w = $signed({v, {W{1'b0}}}) >>> n;
    return {w[W-1], w[2*W-1:W]};
  endfunction

  function automatic logic [W:0] f_ror(logic [W-1:0] v, logic [AW-1:0] n);
    logic [2*W-1:0] w;
    w = {v, v} >> n;
    return {w[W-1], w[W-1:0]};
  endfunction

  logic [W:0] res;
  always_comb begin
    res = {cin, din};
    if (rrx)
      res = {din[0], cin, din[W-1:1]};
    else if (amt != '0) begin
      unique case (kind)
        SH_LSL:  res = f_lsl(din, amt);
        SH_LSR:  res = f_lsr(din, amt);
        SH_ASR:  res = f_asr(din, amt);
        default: res = f_ror(din, amt);
      endcase
    end
  end
  assign cout = res[W];
  assign dout = res[W-1:0];

  always_comb begin
    if (!rrx && amt != '0 && kind == SH_LSL)
      p_lsl_zero_fill_r3: assert (dout[0] == 1'b0);
    if (!rrx && amt != '0 && kind == SH_ASR)
      p_asr_keeps_sign_r7: assert (dout[W-1] == din[W-1]);
  end
endmodule

// File: rtl/opnd_shift_unit.sv
module opnd_shift_unit
  import opsh_pkg::*;
#(
  parameter int W      = 32,
  parameter int IMM_W  = 8,
  parameter int ROT_W  = 4,
  parameter int AMT_W  = 8,
  parameter int PC_ADJ = 4,
  localparam int SW    = $clog2(W),
  localparam int AW    = SW + 1
) (
  input  logic [1:0]       src_sel,
  input  logic [IMM_W-1:0] imm_val,
  input  logic [ROT_W-1:0] rot_fld,
  input  logic [W-1:0]     reg_val,
  input  logic             reg_is_pc,
  input  logic [1:0]       sh_kind,
  input  logic [SW-1:0]    sh_imm,
  input  logic [AMT_W-1:0] amt_lo,
  input  logic             amt_is_pc,
  input  logic             carry_in,
  output logic [W-1:0]     operand,
  output logic             carry_out
);
  // named internal events
  logic             reg_mode;
  logic [W-1:0]     value_eff;
  logic [AMT_W-1:0] amt_byte_eff;
  logic [AW-1:0]    norm_amt;
  logic             use_rrx;
  logic [W-1:0]     rot_data, sh_data;
  logic             rot_carry, sh_carry;
  sh_kind_e         kind;

  assign kind         = sh_kind_e'(sh_kind);
  assign reg_mode     = src_sel[1];
  assign value_eff    = reg_val + ((reg_mode && reg_is_pc) ? W'(PC_ADJ) : W'(0));
  assign amt_byte_eff = amt_lo + (amt_is_pc ? AMT_W'(PC_ADJ) : AMT_W'(0));

  osg_imm_rot #(.W(W), .IMM_W(IMM_W), .ROT_W(ROT_W)) u_rot (
    .imm(imm_val), .rot(rot_fld), .cin(carry_in),
    .dout(rot_data), .cout(rot_carry)
  );

  osg_amount_norm #(.W(W), .AMT_W(AMT_W)) u_norm (
    .reg_mode(reg_mode), .kind(kind), .imm_amt(sh_imm), .reg_amt(amt_byte_eff),
    .amt(norm_amt), .rrx(use_rrx)
  );

  osg_shift_core #(.W(W)) u_core (
    .kind(kind), .amt(norm_amt), .rrx(use_rrx), .din(value_eff), .cin(carry_in),
    .dout(sh_data), .cout(sh_carry)
  );

  assign operand   = (src_sel == SRC_IMM_ROT) ? rot_data  : sh_data;
  assign carry_out = (src_sel == SRC_IMM_ROT) ? rot_carry : sh_carry;

  always_comb begin
    if (reg_mode && amt_byte_eff == '0)
      p_zero_amt_hold_r8: assert (operand == value_eff && carry_out == carry_in);
    if (src_sel == SRC_IMM_AMT && kind == SH_ROR && sh_imm == '0)
      p_rrx_through_carry_r5: assert (operand[W-1] == carry_in && carry_out == reg_val[0]);
    if (src_sel == SRC_IMM_ROT && rot_fld == '0)
      p_imm_unrotated_r1: assert (operand == W'(imm_val) && carry_out == carry_in);
  end
endmodule

// File: tb/test_opnd_shift_unit.sv
module test_opnd_shift_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  src_sel;
  logic [7:0]  imm_val;
  logic [3:0]  rot_fld;
  logic [31:0] reg_val;
  logic        reg_is_pc;
  logic [1:0]  sh_kind;
  logic [4:0]  sh_imm;
  logic [7:0]  amt_lo;
  logic        amt_is_pc;
  logic        carry_in;
  logic [31:0] operand;
  logic        carry_out;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  typedef struct {
    logic [31:0] op;
    logic        c;
    string       tag;
  } exp_t;
  exp_t sb[$];

  always #5 clk = ~clk;

  opnd_shift_unit i_opnd_shift_unit (
    .src_sel(src_sel), .imm_val(imm_val), .rot_fld(rot_fld), .reg_val(reg_val),
    .reg_is_pc(reg_is_pc), .sh_kind(sh_kind), .sh_imm(sh_imm), .amt_lo(amt_lo),
    .amt_is_pc(amt_is_pc), .carry_in(carry_in), .operand(operand), .carry_out(carry_out)
  );

  // step-by-step reference: one bit per step, amount never clamped
  task automatic ref_model(input logic [1:0] s, input logic [7:0] im, input logic [3:0] rt,
                           input logic [31:0] rv, input logic rpc, input logic [1:0] k,
                           input logic [4:0] si, input logic [7:0] al, input logic apc,
                           input logic ci, output logic [31:0] o, output logic c);
    int n;
    o = rv;
    c = ci;
    if (s == 2'd0) begin
      o = {24'd0, im};
      for (int i = 0; i < 2 * rt; i++) begin
        c = o[0];
        o = {o[0], o[31:1]};
      end
    end else if (s == 2'd1 && k == 2'd3 && si == 5'd0) begin
      c = rv[0];
      o = {ci, rv[31:1]};
    end else begin
      if (s[1]) begin
        if (rpc) o = rv + 32'd4;
        n = int'((al + (apc ? 8'd4 : 8'd0)) & 8'hFF);
      end else begin
        n = int'(si);
        if ((k == 2'd1 || k == 2'd2) && n == 0) n = 32;
      end
      for (int i = 0; i < n; i++) begin
        case (k)
          2'd0: begin c = o[31]; o = o << 1; end
          2'd1: begin c = o[0];  o = o >> 1; end
          2'd2: begin c = o[0];  o = {o[31], o[31:1]}; end
          default: begin c = o[0]; o = {o[0], o[31:1]}; end
        endcase
      end
    end
  endtask

  task automatic drive(input logic [1:0] s, input logic [7:0] im, input logic [3:0] rt,
                       input logic [31:0] rv, input logic rpc, input logic [1:0] k,
                       input logic [4:0] si, input logic [7:0] al, input logic apc,
                       input logic ci, input string tag);
    exp_t e;
    @(posedge clk);
    #1;
    src_sel = s; imm_val = im; rot_fld = rt; reg_val = rv; reg_is_pc = rpc;
    sh_kind = k; sh_imm = si; amt_lo = al; amt_is_pc = apc; carry_in = ci;
    ref_model(s, im, rt, rv, rpc, k, si, al, apc, ci, e.op, e.c);
    e.tag = tag;
    sb.push_back(e);
  endtask

  // monitor: combinational result due in the same cycle, sampled at falling edge
  always @(negedge clk) begin
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      checks++;
      if (operand !== e.op || carry_out !== e.c) begin
        errors++;
        $display("FAIL %s: got op=%h c=%b expected op=%h c=%b",
                 e.tag, operand, carry_out, e.op, e.c);
      end
    end
  end

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    src_sel = 0; imm_val = 0; rot_fld = 0; reg_val = 0; reg_is_pc = 0;
    sh_kind = 0; sh_imm = 0; amt_lo = 0; amt_is_pc = 0; carry_in = 0;
    repeat (2) @(posedge clk);
    rst = 1'b0;
    // R2 all-zero state and source decode
    drive(0, 8'h00, 0, 0, 0, 0, 0, 0, 0, 0, "R2");
    drive(1, 8'hFF, 4, 32'h0000_0003, 0, 0, 5'd2, 0, 0, 0, "R2");
    drive(3, 8'hFF, 4, 32'h0000_0003, 0, 0, 5'd9, 8'd1, 0, 0, "R2");
    // R1 immediate rotate
    drive(0, 8'hFF, 4'd4, 0, 0, 0, 0, 0, 0, 0, "R1");
    drive(0, 8'h81, 4'd0, 0, 0, 0, 0, 0, 0, 1, "R1");
    drive(0, 8'h01, 4'd1, 0, 0, 0, 0, 0, 0, 1, "R1");
    drive(0, 8'h02, 4'd15, 0, 0, 0, 0, 0, 0, 0, "R1");
    // R3 kinds and LSL #0
    drive(1, 0, 0, 32'h8000_000F, 0, 2'd0, 5'd0, 0, 0, 1, "R3");
    drive(1, 0, 0, 32'h8000_000F, 0, 2'd0, 5'd4, 0, 0, 0, "R3");
    drive(1, 0, 0, 32'hF000_0010, 0, 2'd2, 5'd4, 0, 0, 0, "R3");
    // R4 immediate 0 means 32
    drive(1, 0, 0, 32'h8000_0001, 0, 2'd1, 5'd0, 0, 0, 0, "R4");
    drive(1, 0, 0, 32'h8000_0000, 0, 2'd2, 5'd0, 0, 0, 0, "R4");
    drive(1, 0, 0, 32'h7FFF_FFFF, 0, 2'd2, 5'd0, 0, 0, 1, "R4");
    // R5 rotate through carry
    drive(1, 0, 0, 32'h0000_0002, 0, 2'd3, 5'd0, 0, 0, 1, "R5");
    drive(1, 0, 0, 32'h0000_0001, 0, 2'd3, 5'd0, 0, 0, 0, "R5");
    // R6 logical saturation
    drive(2, 0, 0, 32'h0000_0001, 0, 2'd0, 0, 8'd32, 0, 0, "R6");
    drive(2, 0, 0, 32'hFFFF_FFFF, 0, 2'd0, 0, 8'd33, 0, 1, "R6");
    drive(2, 0, 0, 32'h8000_0000, 0, 2'd1, 0, 8'd32, 0, 0, "R6");
    drive(2, 0, 0, 32'hFFFF_FFFF, 0, 2'd1, 0, 8'd200, 0, 1, "R6");
    // R7 arithmetic saturation
    drive(2, 0, 0, 32'h8000_0000, 0, 2'd2, 0, 8'd40, 0, 0, "R7");
    drive(2, 0, 0, 32'h7FFF_FFFF, 0, 2'd2, 0, 8'd255, 0, 1, "R7");
    // R8 zero register amount holds
    drive(2, 0, 0, 32'h1234_5678, 0, 2'd3, 0, 8'd0, 0, 1, "R8");
    drive(2, 0, 0, 32'h1234_5678, 0, 2'd1, 0, 8'd0, 0, 1, "R8");
    drive(2, 0, 0, 32'hDEAD_BEEF, 0, 2'd2, 0, 8'd0, 0, 0, "R8");
    // R9 register rotate modulo 32
    drive(2, 0, 0, 32'h8000_0001, 0, 2'd3, 0, 8'd64, 0, 0, "R9");
    drive(2, 0, 0, 32'h1234_5678, 0, 2'd3, 0, 8'd36, 0, 0, "R9");
    drive(2, 0, 0, 32'h0000_0001, 0, 2'd3, 0, 8'd32, 0, 0, "R9");
    // R10 program-counter adjust
    drive(2, 0, 0, 32'h0000_0100, 1, 2'd0, 0, 8'd0, 0, 0, "R10");
    drive(1, 0, 0, 32'h0000_0100, 1, 2'd0, 5'd0, 0, 0, 0, "R10");
    drive(2, 0, 0, 32'h0000_0001, 0, 2'd0, 0, 8'd0, 1, 0, "R10");
    drive(2, 0, 0, 32'h0000_0001, 0, 2'd0, 0, 8'd252, 1, 1, "R10");
    // R11 mixed patterns
    for (int i = 0; i < 400; i++) begin
      drive(2'($urandom), 8'($urandom), 4'($urandom), $urandom, 1'($urandom),
            2'($urandom), 5'($urandom), 8'($urandom % 70), 1'($urandom),
            1'($urandom), "R11");
    end
    repeat (3) @(posedge clk);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule